// File: doc/BRIEF.md
# Section Translation Cache with Address-Space Tags

This block is a small fully associative cache of 1MB section translations. It sits between an address generator and a table walker. Each cycle a requester may present a 32-bit virtual address together with the address-space identifier of the running context. The top twelve address bits form the virtual page number and the low twenty bits are the offset within the section. If a resident entry matches, the block returns the translated physical address and the stored attribute bits in the same cycle. If nothing matches, it raises a miss and returns no translation. An external walker then reads the page table and writes the result back through the refill port.

Each entry records the address-space identifier that was current when it was loaded, plus a non-global flag. A non-global entry serves only the context that loaded it. A global entry serves every context. Entries from several processes can therefore stay resident together across context switches. Software maintenance is covered by two operations: one drops every entry at once, and the other drops only the non-global entries that belong to a chosen identifier. The attribute bits are held and returned but have no effect inside the block.

Top module: `sect_tlb`

## Requirements
- R1: On a lookup that hits, `lk_pa` is the entry's 12-bit section base placed in bits [31:20], joined with `lk_va[19:0]` unchanged. `lk_attr` carries the entry's stored attributes. Both are valid in the same cycle as the request.
- R2: A refill is tagged with the `cur_asid` value present in the refill cycle. An entry loaded with `fill_ng`=1 hits only when the current `cur_asid` equals that tag.
- R3: An entry loaded with `fill_ng`=0 is global and hits for any `cur_asid`.
- R4: A requested lookup that matches no valid entry drives `lk_miss`=1, `lk_hit`=0, and `lk_pa` and `lk_attr` both zero. Without a request, both flags are 0.
- R5: Two different virtual pages that map to the same section base can both be resident, and both hit.
- R6: A refill goes to the lowest-numbered invalid entry. When no entry is invalid, it replaces the entry named by a round-robin pointer. The pointer starts at entry 0 and advances by one, wrapping, only on such a replacement.
- R7: A refill whose page number and tag both equal those of a valid entry overwrites that entry. A later lookup returns the new base and attributes, and no second copy is created.
- R8: `inv_all` clears every entry on the next clock edge.
- R9: `inv_asid` clears only the non-global entries whose tag equals `inv_asid_val`. Global entries and entries with other tags remain resident.
- R10: A refill presented in the same cycle as either invalidate request is dropped. It changes no entry and does not move the pointer.
- R11: After reset, all entries are invalid and the replacement pointer is at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| cur_asid | input | 8 | Address-space identifier of the current context |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_miss | output | 1 | Lookup matched nothing; a walk is needed |
| lk_pa | output | 32 | Translated physical address |
| lk_attr | output | 6 | Stored attribute bits of the hitting entry |
| fill_valid | input | 1 | Refill request from the walker |
| fill_vpn | input | 12 | Virtual page number of the refill |
| fill_base | input | 12 | Physical section base of the refill |
| fill_ng | input | 1 | Non-global flag of the refill |
| fill_attr | input | 6 | Attribute bits of the refill |
| inv_all | input | 1 | Invalidate every entry |
| inv_asid | input | 1 | Invalidate non-global entries of one identifier |
| inv_asid_val | input | 8 | Identifier targeted by `inv_asid` |

## Verification
A lookup result is combinational: it depends on the request presented in that cycle and on the contents held after the previous edge. Refills and invalidations take effect at the edge that samples them. The bench therefore drives each operation just after a rising edge. A monitor compares the lookup outputs against the oldest queued expectation at the following falling edge, so results are checked zero cycles after the request. Every lookup that is meant to observe a refill or invalidation is issued at least one edge after that operation.

// File: rtl/sect_tlb.sv
module sect_tlb #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 20,
  parameter int ASID_W  = 8,
  parameter int ATTR_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_valid,
  input  logic [VA_W-1:0]         lk_va,
  input  logic [ASID_W-1:0]       cur_asid,
  output logic                    lk_hit,
  output logic                    lk_miss,
  output logic [VA_W-1:0]         lk_pa,
  output logic [ATTR_W-1:0]       lk_attr,
  input  logic                    fill_valid,
  input  logic [VA_W-OFF_W-1:0]   fill_vpn,
  input  logic [VA_W-OFF_W-1:0]   fill_base,
  input  logic                    fill_ng,
  input  logic [ATTR_W-1:0]       fill_attr,
  input  logic                    inv_all,
  input  logic                    inv_asid,
  input  logic [ASID_W-1:0]       inv_asid_val
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld, ngl;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [VPN_W-1:0]   base_q [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [ATTR_W-1:0]  attr_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] hit_vec, same_vec, kill_vec;
  logic [IDX_W-1:0]   hit_idx, same_idx, free_idx, victim;
  logic               any_hit, any_same, any_free, do_fill, replace;

  assign lk_vpn = lk_va[VA_W-1:OFF_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_match
    assign hit_vec[i]  = vld[i] && vpn_q[i] == lk_vpn && (!ngl[i] || asid_q[i] == cur_asid);
    assign same_vec[i] = vld[i] && vpn_q[i] == fill_vpn && asid_q[i] == cur_asid;
    assign kill_vec[i] = vld[i] && ngl[i] && asid_q[i] == inv_asid_val;
  end

  always_comb begin
    hit_idx  = '0;
    same_idx = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i])  hit_idx  = IDX_W'(i);
      if (same_vec[i]) same_idx = IDX_W'(i);
      if (!vld[i])     free_idx = IDX_W'(i);
    end
  end

  assign any_hit  = |hit_vec;
  assign any_same = |same_vec;
  assign any_free = ~&vld;
  assign victim   = any_same ? same_idx : (any_free ? free_idx : rr_q);
  assign do_fill  = fill_valid && !inv_all && !inv_asid;
  assign replace  = do_fill && !any_same && !any_free;

  assign lk_hit  = lk_valid && any_hit;
  assign lk_miss = lk_valid && !any_hit;
  assign lk_pa   = lk_hit ? {base_q[hit_idx], lk_va[OFF_W-1:0]} : '0;
  assign lk_attr = lk_hit ? attr_q[hit_idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= '0;
      rr_q <= '0;
    end else if (inv_all) begin
      vld <= '0;
    end else if (inv_asid) begin
      vld <= vld & ~kill_vec;
    end else if (do_fill) begin
      vld[victim] <= 1'b1;
      if (replace) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      vpn_q[victim]  <= fill_vpn;
      base_q[victim] <= fill_base;
      asid_q[victim] <= cur_asid;
      attr_q[victim] <= fill_attr;
      ngl[victim]    <= fill_ng;
    end
  end

  logic [VPN_W-1:0]   chk_vpn;
  logic [ASID_W-1:0]  chk_asid, chk_inv;
  logic [ENTRIES-1:0] dup_vec, left_vec;

  always_ff @(posedge clk) begin
    chk_vpn  <= fill_vpn;
    chk_asid <= cur_asid;
    chk_inv  <= inv_asid_val;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
    assign dup_vec[i]  = vld[i] && vpn_q[i] == chk_vpn && asid_q[i] == chk_asid;
    assign left_vec[i] = vld[i] && ngl[i] && asid_q[i] == chk_inv;
  end

  AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]);                        // R1
  AST_MISS_NO_XLATE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> !lk_hit && lk_pa == '0);                                      // R4
  AST_ONE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !inv_all && !inv_asid) |=> $countones(dup_vec) == 1);     // R7
  AST_INV_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> vld == '0);                                                   // R8
  AST_INV_ASID_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_asid && !inv_all) |=> left_vec == '0);                               // R9
  AST_INV_ASID_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_asid && !inv_all) |=> (vld & ~ngl) == $past(vld & ~ngl));           // R9
  AST_INV_DROPS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && inv_asid && !inv_all) |=> $stable(rr_q));                  // R10
endmodule

// File: tb/sect_tlb_bench.sv
module sect_tlb_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_va = '0;
  logic [7:0]  cur_asid = '0;
  logic        lk_hit, lk_miss;
  logic [31:0] lk_pa;
  logic [5:0]  lk_attr;
  logic        fill_valid = 1'b0;
  logic [11:0] fill_vpn = '0, fill_base = '0;
  logic        fill_ng = 1'b0;
  logic [5:0]  fill_attr = '0;
  logic        inv_all = 1'b0, inv_asid = 1'b0;
  logic [7:0]  inv_asid_val = '0;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        hit;
    logic [31:0] pa;
    logic [5:0]  attr;
    string       req;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  sect_tlb u_sect_tlb (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .cur_asid(cur_asid),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa), .lk_attr(lk_attr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_base(fill_base), .fill_ng(fill_ng),
    .fill_attr(fill_attr), .inv_all(inv_all), .inv_asid(inv_asid), .inv_asid_val(inv_asid_val)
  );

  always @(negedge clk) begin
    if (lk_valid && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (lk_hit !== e.hit || lk_miss !== !e.hit || lk_pa !== e.pa || lk_attr !== e.attr) begin
        errors++;
        $display("FAIL %s: hit=%0b miss=%0b pa=%h attr=%h, expected hit=%0b pa=%h attr=%h",
                 e.req, lk_hit, lk_miss, lk_pa, lk_attr, e.hit, e.pa, e.attr);
      end
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    lk_valid = 0; fill_valid = 0; inv_all = 0; inv_asid = 0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic hit,
                        input logic [11:0] base, input logic [5:0] attr, input string req);
    exp_t e;
    @(posedge clk); #1;
    fill_valid = 0; inv_all = 0; inv_asid = 0;
    lk_valid = 1; lk_va = va; cur_asid = asid;
    e.hit = hit;
    e.pa = hit ? {base, va[19:0]} : 32'h0;
    e.attr = hit ? attr : 6'h0;
    e.req = req;
    q.push_back(e);
  endtask

  task automatic fill(input logic [11:0] vpn, input logic [11:0] base, input logic ng,
                      input logic [5:0] attr, input logic [7:0] asid,
                      input logic with_all, input logic with_asid);
    @(posedge clk); #1;
    lk_valid = 0;
    fill_valid = 1; fill_vpn = vpn; fill_base = base; fill_ng = ng; fill_attr = attr;
    cur_asid = asid; inv_all = with_all; inv_asid = with_asid; inv_asid_val = 8'h07;
  endtask

  task automatic kill_asid(input logic [7:0] id);
    @(posedge clk); #1;
    lk_valid = 0; fill_valid = 0; inv_all = 0;
    inv_asid = 1; inv_asid_val = id;
  endtask

  task automatic finish_run();
    idle();
    @(negedge clk); @(negedge clk);
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: %0d results outstanding, expected 0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1600000;
    checks++; errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (lk_hit !== 0 || lk_miss !== 0) begin
      errors++;
      $display("FAIL R4 idle flags: hit=%0b miss=%0b, expected 0 0", lk_hit, lk_miss);
    end
    lookup(32'h3F20_000C, 8'h05, 0, 0, 0, "R11 empty after reset");
    lookup(32'h0000_1000, 8'h00, 0, 0, 0, "R4 miss on empty");

    fill(12'h002, 12'h3F2, 1, 6'h15, 8'h05, 0, 0);
    lookup(32'h0020_000C, 8'h05, 1, 12'h3F2, 6'h15, "R1 hit pa and attr");
    lookup(32'h0020_000C, 8'h06, 0, 0, 0, "R2 non-global other asid misses");
    fill(12'h3F2, 12'h3F2, 0, 6'h2A, 8'h05, 0, 0);
    lookup(32'h3F20_0020, 8'h09, 1, 12'h3F2, 6'h2A, "R3 global any asid");
    lookup(32'h3F2F_FFFF, 8'h05, 1, 12'h3F2, 6'h2A, "R5 alias page A");
    lookup(32'h0020_002C, 8'h05, 1, 12'h3F2, 6'h15, "R5 alias page B");
    fill(12'h002, 12'h400, 1, 6'h01, 8'h06, 0, 0);
    lookup(32'h0020_0010, 8'h06, 1, 12'h400, 6'h01, "R2 second context own entry");
    lookup(32'h0020_0010, 8'h05, 1, 12'h3F2, 6'h15, "R2 first context keeps entry");
    fill(12'h002, 12'h123, 1, 6'h07, 8'h05, 0, 0);
    lookup(32'h0020_0004, 8'h05, 1, 12'h123, 6'h07, "R7 refill overwrites");

    kill_asid(8'h05);
    lookup(32'h0020_0004, 8'h05, 0, 0, 0, "R9 matching non-global cleared");
    lookup(32'h3F20_0000, 8'h05, 1, 12'h3F2, 6'h2A, "R9 global kept");
    lookup(32'h0020_0004, 8'h06, 1, 12'h400, 6'h01, "R9 other asid kept");

    fill(12'h077, 12'h077, 0, 6'h03, 8'h00, 1, 0);
    lookup(32'h0770_0000, 8'h00, 0, 0, 0, "R10 fill dropped under invalidate-all");
    lookup(32'h3F20_0000, 8'h05, 0, 0, 0, "R8 global cleared");
    lookup(32'h0020_0004, 8'h06, 0, 0, 0, "R8 non-global cleared");

    for (int i = 0; i < 8; i++)
      fill(12'h100 + 12'(i), 12'h300 + 12'(i), 0, 6'(i), 8'h00, 0, 0);
    for (int i = 0; i < 8; i++)
      lookup({12'h100 + 12'(i), 20'h00ABC}, 8'h00, 1, 12'h300 + 12'(i), 6'(i), "R6 fill free slots");
    fill(12'h108, 12'h308, 0, 6'h08, 8'h00, 0, 0);
    lookup(32'h1000_0000, 8'h00, 0, 0, 0, "R6 first replacement evicts entry 0");
    lookup(32'h1010_0000, 8'h00, 1, 12'h301, 6'h01, "R6 entry 1 kept");
    lookup(32'h1080_0000, 8'h00, 1, 12'h308, 6'h08, "R6 new entry present");
    fill(12'h109, 12'h309, 0, 6'h09, 8'h00, 0, 0);
    lookup(32'h1010_0000, 8'h00, 0, 0, 0, "R6 second replacement evicts entry 1");
    lookup(32'h1020_0000, 8'h00, 1, 12'h302, 6'h02, "R6 entry 2 kept");

    fill(12'h150, 12'h150, 1, 6'h04, 8'h03, 0, 1);
    lookup(32'h1500_0000, 8'h03, 0, 0, 0, "R10 fill dropped under asid invalidate");
    lookup(32'h1020_0000, 8'h00, 1, 12'h302, 6'h02, "R10 no eviction by dropped fill");
    fill(12'h10A, 12'h30A, 0, 6'h0A, 8'h00, 0, 0);
    lookup(32'h1020_0000, 8'h00, 0, 0, 0, "R10 pointer not moved by dropped fill");

    finish_run();
  end
endmodule